// File: doc/BRIEF.md
# Bit-Slice Integer ALU with Operand Inversion

This block is a combinational integer ALU assembled from identical one-bit cells chained by a ripple carry. Each cell can complement either operand bit. It holds an AND gate, an OR gate and a full adder, and a two-bit selector picks which of these, or an external "less" bit, drives the cell output. The block uses these cells to give six operations. Subtraction complements B and forces the first carry-in to one. NOR complements both operands and takes the AND path. Signed set-on-less-than feeds the overflow-corrected sign of A−B back into the least significant cell.

The block is used as the execute stage of a simple integer datapath. The operation is chosen by a 4-bit code whose bits are, from MSB to LSB: invert-A, invert-B, then the 2-bit selector. The block drives a result word and a zero flag in the same cycle as its inputs, and it holds no state. Its selector is an enumerated type with four named values: SEL_AND, SEL_OR, SEL_SUM and SEL_LESS.

Top module: `bitslice_alu`

## Requirements
- R1: The code is read as ctrl[3] = invert A, ctrl[2] = invert B and ctrl[1:0] = selector. Code 4'b0000 gives result = a AND b.
- R2: Code 4'b0001 gives result = a OR b.
- R3: Code 4'b0010 gives result = (a + b) mod 2^WIDTH, and the final carry is discarded.
- R4: Code 4'b0110 gives result = (a − b) mod 2^WIDTH, formed as a + ~b + 1.
- R5: Code 4'b0111 gives result = 1 when a is less than b as two's-complement numbers, and 0 otherwise. The result is correct even when a − b overflows, and all upper bits are 0.
- R6: Code 4'b1100 gives result = NOT (a OR b).
- R7: Every other code (0011, 0100, 0101, 1000 to 1011, 1101 to 1111) gives result = 0.
- R8: zero is 1 exactly when every result bit is 0. This includes the unlisted codes of R7.
- R9: result and zero follow a_in, b_in and ctrl with no clock. No register lies on any path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| ctrl | input | 4 | Operation code: {invert A, invert B, selector[1:0]} |
| result | output | WIDTH | Selected operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The sign correction for set-on-less-than and the zero flag are both decided in one evaluation. They interact when the subtraction overflows. The bench provokes this with operand pairs that straddle the signed range, such as 0x80000000 against 1 and 0x7FFFFFFF against 0xFFFFFFFF. For each pair it compares the one-bit slt answer and the zero flag against a signed comparison and a reduction computed in the bench. It also sweeps every one of the 16 codes over these corner operands and over a pseudo-random set, so that subtract with equal operands (zero high) and the unlisted codes (zero high, result 0) are judged against the same arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } op_sel_e;

    localparam logic [3:0] CODE_AND = 4'b0000;
    localparam logic [3:0] CODE_OR  = 4'b0001;
    localparam logic [3:0] CODE_ADD = 4'b0010;
    localparam logic [3:0] CODE_SUB = 4'b0110;
    localparam logic [3:0] CODE_SLT = 4'b0111;
    localparam logic [3:0] CODE_NOR = 4'b1100;

endpackage

// File: rtl/alu_ctrl_decode.sv
module alu_ctrl_decode
    import alu_pkg::*;
(
    input  logic [3:0] ctrl,
    output logic       inv_a,
    output logic       inv_b,
    output op_sel_e    sel,
    output logic       legal
);

    // Field split: [3] invert A, [2] invert B, [1:0] selector
    assign inv_a = ctrl[3];
    assign inv_b = ctrl[2];
    assign sel   = op_sel_e'(ctrl[1:0]);

    always_comb begin
        unique case (ctrl)
            CODE_AND, CODE_OR, CODE_ADD,
            CODE_SUB, CODE_SLT, CODE_NOR: legal = 1'b1;
            default:                      legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic    a,
    input  logic    b,
    input  logic    inv_a,
    input  logic    inv_b,
    input  logic    carry_in,
    input  logic    less_in,
    input  op_sel_e sel,
    output logic    bit_out,
    output logic    sum_out,
    output logic    carry_out
);

    logic a_eff;
    logic b_eff;

    assign a_eff     = a ^ inv_a;
    assign b_eff     = b ^ inv_b;
    assign sum_out   = a_eff ^ b_eff ^ carry_in;
    assign carry_out = (a_eff & b_eff) | (carry_in & (a_eff ^ b_eff));

    always_comb begin
        unique case (sel)
            SEL_AND:  bit_out = a_eff & b_eff;
            SEL_OR:   bit_out = a_eff | b_eff;
            SEL_SUM:  bit_out = sum_out;
            SEL_LESS: bit_out = less_in;
            default:  bit_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    output logic             is_zero
);

    assign is_zero = (value == '0);

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [3:0]       ctrl,
    output logic [WIDTH-1:0] result,
    output logic             zero
);

    localparam int MSB = WIDTH - 1;

    logic             inv_a;
    logic             inv_b;
    op_sel_e          sel;
    logic             legal;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sums;
    logic [WIDTH-1:0] raw;
    logic             set_less;

    alu_ctrl_decode u_dec (
        .ctrl  (ctrl),
        .inv_a (inv_a),
        .inv_b (inv_b),
        .sel   (sel),
        .legal (legal)
    );

    // Invert-B doubles as the first carry-in, giving a + ~b + 1
    assign carry[0] = inv_b;

    // Overflow-corrected sign of a - b drives the LSB "less" input
    assign set_less = sums[MSB] ^ (carry[MSB] ^ carry[WIDTH]);

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_bit;
        if (i == 0) begin : g_lsb
            assign less_bit = set_less;
        end else begin : g_upper
            assign less_bit = 1'b0;
        end

        alu_slice u_slice (
            .a         (a_in[i]),
            .b         (b_in[i]),
            .inv_a     (inv_a),
            .inv_b     (inv_b),
            .carry_in  (carry[i]),
            .less_in   (less_bit),
            .sel       (sel),
            .bit_out   (raw[i]),
            .sum_out   (sums[i]),
            .carry_out (carry[i+1])
        );
    end

    assign result = legal ? raw : '0;

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .value   (result),
        .is_zero (zero)
    );

    // Cross-checks of the slice chain against word-level arithmetic
    always_comb begin
        if (!$isunknown({a_in, b_in, ctrl})) begin
            if (ctrl == CODE_AND) AST_AND_WORD: assert (result == (a_in & b_in)); // R1
            if (ctrl == CODE_OR)  AST_OR_WORD:  assert (result == (a_in | b_in)); // R2
            if (ctrl == CODE_ADD) AST_ADD_WORD: assert (result == WIDTH'(a_in + b_in)); // R3
            if (ctrl == CODE_SUB) AST_SUB_WORD: assert (result == WIDTH'(a_in - b_in)); // R4
            if (ctrl == CODE_SLT) AST_SLT_WORD: assert (result == {{MSB{1'b0}}, ($signed(a_in) < $signed(b_in))}); // R5
            if (ctrl == CODE_NOR) AST_NOR_WORD: assert (result == ~(a_in | b_in)); // R6
            if (!legal) AST_ILLEGAL_ZERO: assert (result == '0 && zero); // R7
            if (ctrl == CODE_SUB) AST_ZERO_EQUAL: assert (zero == (a_in == b_in)); // R8
        end
    end

endmodule

// File: tb/tb_bitslice_alu.sv
`timescale 1ns/1ps
module tb_bitslice_alu;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [3:0]   ctrl = 4'b0000;
    logic [W-1:0] result;
    logic         zero;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    bitslice_alu #(.WIDTH(W)) dut (
        .a_in   (a_in),
        .b_in   (b_in),
        .ctrl   (ctrl),
        .result (result),
        .zero   (zero)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic [3:0] c);
        case (c)
            4'b0000: return a & b;                         // R1
            4'b0001: return a | b;                         // R2
            4'b0010: return a + b;                         // R3
            4'b0110: return a - b;                         // R4
            4'b0111: return ($signed(a) < $signed(b)) ? 1 : 0; // R5
            4'b1100: return ~(a | b);                      // R6
            default: return '0;                            // R7
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R5";
            4'b1100: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
        logic [W-1:0] exp_r;
        @(posedge clk);
        a_in = a; b_in = b; ctrl = c;
        @(negedge clk); // R9: combinational, settled half a cycle later
        exp_r = model(a, b, c);
        checks++;
        if (result !== exp_r) begin
            errors++;
            $display("FAIL %s ctrl=%b a=%h b=%h result=%h expected=%h", tag_of(c), c, a, b, result, exp_r);
        end
        checks++;
        if (zero !== (exp_r == '0)) begin
            errors++;
            $display("FAIL R8 ctrl=%b a=%h b=%h zero=%b expected=%b", c, a, b, zero, (exp_r == '0));
        end
    endtask

    logic [W-1:0] corners [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                                  32'h7FFF_FFFF, 32'hAAAA_AAAA, 32'h5555_5555, 32'h1234_5678};

    initial begin
        logic [W-1:0] lfsr;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-state: all-zero inputs, AND code
        @(negedge clk);
        checks++;
        if (result !== '0 || zero !== 1'b1) begin
            errors++;
            $display("FAIL R8 idle result=%h zero=%b expected=0 1", result, zero);
        end
        // R5 overflow corners explicitly
        apply(32'h8000_0000, 32'h0000_0001, 4'b0111);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
        apply(32'h1234_5678, 32'h1234_5678, 4'b0110);
        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(corners[i], corners[j], 4'(c));
        lfsr = 32'hACE1_2468;
        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] ra;
            ra = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            for (int c = 0; c < 16; c++)
                apply(ra, lfsr, 4'(c));
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule